// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out one indivisible read-modify-write on a 32-bit or 64-bit location in memory. A requester gives it a 5-bit function code, a byte address, a 64-bit operand, a size select and a variant select. The load variant returns the value memory held before the update. The store variant writes the combined value and returns zero. The unit reads the location, combines the old value with the operand, and writes the result back. A lock output is held for the whole time it owns the location, so the memory side can keep other masters away.

Before any access, the unit sorts the function code into one of three groups. Supported codes go on to memory. Codes that are architected but not built here raise an illegal-instruction error. All other codes raise a storage error. A supported request whose address is not naturally aligned also raises a storage error. An errored request never touches memory. Its error flag is asserted together with the one-cycle completion pulse.

Top module: `atomic_rmw_unit`

## Requirements
- R1: With the load variant (`req_store`=0), code 0 adds, 1 XORs, 2 ORs, 3 ANDs and 8 swaps (writes the operand). Memory receives the combined value, and `rsp_data` carries the value read before the update.
- R2: With the store variant (`req_store`=1), codes 0 to 3 write add/XOR/OR/AND of old value and operand, and `rsp_data` is zero at completion.
- R3: These codes assert `err_illegal` and make no memory access: for the load variant 4, 5, 6, 7, 16, 24, 25 and 28; for the store variant 4, 5, 6, 7 and 24.
- R4: Every code not listed in R1 to R3 for its variant (including 8 for the store variant) asserts `err_storage` and makes no memory access.
- R5: A supported request with `req_dword`=1 and any of address bits [2:0] set, or with `req_dword`=0 and any of bits [1:0] set, asserts `err_storage` and makes no access. A code error from R3 or R4 takes precedence over misalignment.
- R6: A word access (`req_dword`=0) computes on bits [31:0] only, with modulo-2^32 addition. Write data bits [63:32] are zero, and the returned old value is zero-extended.
- R7: A supported request issues exactly one read and then one write at the request address. Each waits for `mem_ready`. `mem_lock` is high on every cycle that `mem_rd` or `mem_wr` is high, and `mem_addr` holds steady while locked.
- R8: `rsp_done` is a single-cycle pulse. Error flags and `rsp_data` are non-zero only with it. `req_ready` is high only when idle, and a request presented while busy is ignored.
- R9: During and right after reset the unit is idle: `req_ready`=1 and `mem_rd`, `mem_wr`, `mem_lock` and `rsp_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_store | input | 1 | 0 = load variant, 1 = store variant |
| req_dword | input | 1 | 0 = 32-bit access, 1 = 64-bit access |
| req_func | input | 5 | Function code |
| req_addr | input | ADDR_W | Byte address |
| req_operand | input | DATA_W | Operand value |
| rsp_done | output | 1 | Completion pulse |
| rsp_data | output | DATA_W | Old memory value (load variant, no error), else zero |
| err_illegal | output | 1 | Unimplemented code, valid with `rsp_done` |
| err_storage | output | 1 | Undefined code or misalignment, valid with `rsp_done` |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_lock | output | 1 | Location held across read and write |
| mem_dword | output | 1 | Access size toward memory |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data (word in bits [31:0]) |
| mem_rdata | input | DATA_W | Read data (word in bits [31:0]) |
| mem_ready | input | 1 | Memory completes current strobe |

## Verification
A fault in the code sorting shows up in the same cycle as the completion pulse. The wrong error flag rises, or a read strobe appears where none should, only one cycle after acceptance. A corrupted captured value or operation select stays hidden until the write strobe. It then appears as wrong write data, and later as a wrong returned value. A fault in the sequence shows at the memory port within a cycle of the missing `mem_ready`, as an unlocked strobe, a moving address or a second access. The bench sweeps every code under both variants and both sizes, with memory stalls that vary from request to request, and checks each of these symptoms.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  localparam int FUNC_W = 5;

  typedef enum logic [2:0] {OP_ADD, OP_XOR, OP_OR, OP_AND, OP_SWAP} rmw_op_e;
  typedef enum logic [1:0] {CODE_OK, CODE_ILLEGAL, CODE_UNDEF} code_class_e;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE} rmw_state_e;
endpackage

// File: rtl/atomic_rmw_decode.sv
module atomic_rmw_decode
  import atomic_rmw_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  input  logic              is_store,
  output rmw_op_e           op,
  output code_class_e       cls
);
  always_comb begin
    op  = OP_ADD;
    cls = CODE_UNDEF;
    case (func)
      5'd0: begin op = OP_ADD; cls = CODE_OK; end
      5'd1: begin op = OP_XOR; cls = CODE_OK; end
      5'd2: begin op = OP_OR;  cls = CODE_OK; end
      5'd3: begin op = OP_AND; cls = CODE_OK; end
      5'd4, 5'd5, 5'd6, 5'd7, 5'd24: cls = CODE_ILLEGAL;
      5'd8: begin
        op  = OP_SWAP;
        cls = is_store ? CODE_UNDEF : CODE_OK;
      end
      5'd16, 5'd25, 5'd28: cls = is_store ? CODE_UNDEF : CODE_ILLEGAL;
      default: cls = CODE_UNDEF;
    endcase
  end
endmodule

// File: rtl/atomic_rmw_align.sv
module atomic_rmw_align #(
  parameter int LG = 3
) (
  input  logic [LG-1:0] addr_lo,
  input  logic          dword,
  output logic          misaligned
);
  localparam int WLG = LG - 1;

  always_comb begin
    if (dword) misaligned = |addr_lo;
    else       misaligned = |addr_lo[WLG-1:0];
  end
endmodule

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  rmw_op_e           op,
  input  logic              dword,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] new_val
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] a, b, r;

  always_comb begin
    a = dword ? old_val : {{HALF_W{1'b0}}, old_val[HALF_W-1:0]};
    b = dword ? operand : {{HALF_W{1'b0}}, operand[HALF_W-1:0]};
    case (op)
      OP_ADD:  r = a + b;
      OP_XOR:  r = a ^ b;
      OP_OR:   r = a | b;
      OP_AND:  r = a & b;
      OP_SWAP: r = b;
      default: r = a;
    endcase
    new_val = dword ? r : {{HALF_W{1'b0}}, r[HALF_W-1:0]};
  end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic              req_dword,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_operand,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_data,
  output logic              err_illegal,
  output logic              err_storage,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_lock,
  output logic              mem_dword,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  localparam int HALF_W = DATA_W / 2;
  localparam int LG     = $clog2(DATA_W / 8);

  rmw_state_e        state_q, state_d;
  rmw_op_e           dec_op, op_q;
  code_class_e       dec_cls;
  logic              misal;
  logic              accept, cap_old;
  logic              store_q, dword_q, eill_q, esto_q;
  logic              eill_d, esto_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] operand_q, old_q, old_d;

  atomic_rmw_decode u_decode (
    .func     (req_func),
    .is_store (req_store),
    .op       (dec_op),
    .cls      (dec_cls)
  );

  atomic_rmw_align #(.LG(LG)) u_align (
    .addr_lo    (req_addr[LG-1:0]),
    .dword      (req_dword),
    .misaligned (misal)
  );

  atomic_rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (op_q),
    .dword   (dword_q),
    .old_val (old_q),
    .operand (operand_q),
    .new_val (mem_wdata)
  );

  // next-state and enables
  always_comb begin
    state_d = state_q;
    accept  = (state_q == ST_IDLE) && req_valid;
    cap_old = (state_q == ST_READ) && mem_ready;
    eill_d  = (dec_cls == CODE_ILLEGAL);
    esto_d  = (dec_cls == CODE_UNDEF) || ((dec_cls == CODE_OK) && misal);
    old_d   = req_dword_sel(dword_q, mem_rdata);
    case (state_q)
      ST_IDLE:  if (req_valid) state_d = (eill_d || esto_d) ? ST_DONE : ST_READ;
      ST_READ:  if (mem_ready) state_d = ST_WRITE;
      ST_WRITE: if (mem_ready) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  function automatic logic [DATA_W-1:0] req_dword_sel(input logic dw,
                                                      input logic [DATA_W-1:0] v);
    return dw ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q   <= 1'b0;
      dword_q   <= 1'b0;
      op_q      <= OP_ADD;
      addr_q    <= '0;
      operand_q <= '0;
      eill_q    <= 1'b0;
      esto_q    <= 1'b0;
    end else if (accept) begin
      store_q   <= req_store;
      dword_q   <= req_dword;
      op_q      <= dec_op;
      addr_q    <= req_addr;
      operand_q <= req_operand;
      eill_q    <= eill_d;
      esto_q    <= esto_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       old_q <= '0;
    else if (cap_old) old_q <= old_d;
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign rsp_done    = (state_q == ST_DONE);
  assign err_illegal = rsp_done && eill_q;
  assign err_storage = rsp_done && esto_q;
  assign rsp_data    = (rsp_done && !store_q && !eill_q && !esto_q) ? old_q : '0;
  assign mem_rd      = (state_q == ST_READ);
  assign mem_wr      = (state_q == ST_WRITE);
  assign mem_lock    = mem_rd || mem_wr;
  assign mem_dword   = dword_q;
  assign mem_addr    = addr_q;

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, rsp_done}));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  assert_addr_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && $past(mem_lock)) |-> $stable(mem_addr));
  assert_write_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr) |-> $past(mem_rd && mem_ready));
  assert_error_no_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && (err_illegal || err_storage)) |-> $past(req_ready));
  assert_error_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_illegal && err_storage));
  assert_word_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_dword) |-> (mem_wdata[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/atomic_rmw_unit_tb.sv
module atomic_rmw_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_store, req_dword;
  logic [4:0]  req_func;
  logic [31:0] req_addr;
  logic [63:0] req_operand;
  logic        rsp_done, err_illegal, err_storage;
  logic [63:0] rsp_data;
  logic        mem_rd, mem_wr, mem_lock, mem_dword, mem_ready;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  int n_rd, n_wr, dly, wcnt;
  logic [63:0] mem [8];

  always #(CLK_P/2) clk = ~clk;

  atomic_rmw_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_dword(req_dword), .req_func(req_func),
    .req_addr(req_addr), .req_operand(req_operand), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .err_illegal(err_illegal), .err_storage(err_storage),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_lock(mem_lock), .mem_dword(mem_dword),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model with variable stall, responds at negedge
  always @(negedge clk) begin
    if (mem_rd || mem_wr) begin
      if (!mem_lock) chk("R7 lock with strobe", 64'(mem_lock), 64'd1);
      if (wcnt >= dly) begin
        mem_ready = 1'b1;
        wcnt = 0;
        if (mem_rd) begin
          n_rd++;
          if (mem_dword) mem_rdata = mem[mem_addr[5:3]];
          else mem_rdata = {32'h0, mem_addr[2] ? mem[mem_addr[5:3]][63:32]
                                               : mem[mem_addr[5:3]][31:0]};
        end else begin
          n_wr++;
          if (!mem_dword && mem_wdata[63:32] != 0)
            chk("R6 word write upper half", mem_wdata, {32'h0, mem_wdata[31:0]});
          if (mem_dword) mem[mem_addr[5:3]] = mem_wdata;
          else if (mem_addr[2]) mem[mem_addr[5:3]][63:32] = mem_wdata[31:0];
          else mem[mem_addr[5:3]][31:0] = mem_wdata[31:0];
        end
      end else begin
        mem_ready = 1'b0;
        wcnt++;
      end
    end else begin
      mem_ready = 1'b0;
      wcnt = 0;
    end
  end

  // 0 supported, 1 illegal, 2 undefined
  function automatic int classify(input bit st, input int f);
    if (!st) begin
      if (f inside {0, 1, 2, 3, 8}) return 0;
      if (f inside {4, 5, 6, 7, 16, 24, 25, 28}) return 1;
    end else begin
      if (f inside {0, 1, 2, 3}) return 0;
      if (f inside {4, 5, 6, 7, 24}) return 1;
    end
    return 2;
  endfunction

  function automatic logic [63:0] combine(input int f, input bit dw,
                                          input logic [63:0] o, input logic [63:0] p);
    logic [63:0] r;
    case (f)
      0: r = o + p;
      1: r = o ^ p;
      2: r = o | p;
      3: r = o & p;
      default: r = p;
    endcase
    return dw ? r : {32'h0, r[31:0]};
  endfunction

  task automatic run_op(input bit st, input bit dw, input int f, input logic [31:0] addr,
                        input logic [63:0] init, input logic [63:0] opnd, input int hold);
    int idx, cls, k;
    bit mis, ok;
    logic [63:0] oldv, newv, exp_mem;
    idx = int'(addr[5:3]);
    mem[idx] = init;
    cls = classify(st, f);
    mis = dw ? (addr[2:0] != 0) : (addr[1:0] != 0);
    ok = (cls == 0) && !mis;
    oldv = dw ? init : {32'h0, addr[2] ? init[63:32] : init[31:0]};
    newv = combine(f, dw, oldv, opnd);
    exp_mem = init;
    if (ok) begin
      if (dw) exp_mem = newv;
      else if (addr[2]) exp_mem[63:32] = newv[31:0];
      else exp_mem[31:0] = newv[31:0];
    end
    n_rd = 0; n_wr = 0;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_dword = dw; req_func = 5'(f);
    req_addr = addr; req_operand = opnd;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      req_func = 5'd4; req_addr = addr ^ 32'h8; req_operand = ~opnd;
    end
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (!rsp_done && k < 60) begin
      @(negedge clk);
      k++;
    end
    chk("R8 done reached", 64'(rsp_done), 64'd1);
    chk("R3 illegal flag", 64'(err_illegal), 64'(cls == 1));
    chk("R4 R5 storage flag", 64'(err_storage), 64'(cls == 2 || (cls == 0 && mis)));
    if (ok && !st) chk(dw ? "R1 old value" : "R6 old value zero-ext", rsp_data, oldv);
    else chk("R2 no data returned", rsp_data, 64'h0);
    @(negedge clk);
    chk("R8 done one cycle", 64'(rsp_done), 64'd0);
    chk("R8 idle again", 64'(req_ready), 64'd1);
    chk(ok ? (st ? "R2 stored value" : "R1 stored value") : "R4 memory untouched",
        mem[idx], exp_mem);
    chk("R7 read count", 64'(n_rd), 64'(ok));
    chk("R7 write count", 64'(n_wr), 64'(ok));
  endtask

  logic [63:0] olds [3];
  logic [63:0] opns [3];

  initial begin
    #(CLK_P * 190000);
    chk("watchdog expired", 64'd1, 64'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    olds[0] = 64'h0123_4567_FFFF_FFFF; opns[0] = 64'h0000_0001_0000_0001;
    olds[1] = 64'hFFFF_FFFF_8000_0000; opns[1] = 64'h8000_0000_8000_0000;
    olds[2] = 64'hA5A5_5A5A_0F0F_F0F0; opns[2] = 64'h3C3C_C3C3_FF00_00FF;
    for (int i = 0; i < 8; i++) mem[i] = '0;
    mem_ready = 0; mem_rdata = '0; dly = 0; wcnt = 0;
    req_valid = 0; req_store = 0; req_dword = 0; req_func = '0;
    req_addr = '0; req_operand = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 ready in reset", 64'(req_ready), 64'd1);
    chk("R9 no strobes in reset", 64'({mem_rd, mem_wr, mem_lock, rsp_done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", 64'({req_ready, mem_rd, mem_wr, mem_lock, rsp_done}), 64'h10);

    // full code sweep, both variants and sizes
    for (int st = 0; st < 2; st++)
      for (int dw = 0; dw < 2; dw++)
        for (int f = 0; f < 32; f++)
          for (int p = 0; p < 3; p++) begin
            logic [31:0] a;
            dly = (f + p) % 3;
            a = {26'h0, 3'(f % 8), 3'b000};
            if (dw == 0 && (p % 2) == 1) a[2] = 1'b1;
            run_op(bit'(st), bit'(dw), f, a, olds[p], opns[p], 0);
          end

    // alignment sweep (R5), supported code 0
    for (int dw = 0; dw < 2; dw++)
      for (int off = 0; off < 8; off++) begin
        dly = off % 2;
        run_op(1'b0, bit'(dw), 0, 32'h18 + 32'(off), olds[2], opns[0], 0);
      end
    // R5 precedence: code errors win over misalignment
    run_op(1'b0, 1'b1, 4, 32'h21, olds[0], opns[0], 0);
    run_op(1'b1, 1'b0, 9, 32'h23, olds[0], opns[0], 0);

    // R8 requests held while busy are ignored
    for (int d = 0; d < 3; d++) begin
      dly = d;
      run_op(1'b0, 1'b1, 0, 32'h30, olds[0], opns[2], 2);
      run_op(1'b1, 1'b0, 1, 32'h2C, olds[1], opns[1], 2);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule